// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the 32-bit word-access register front end for a bank of DMA channels. A simple request port (request, write enable, 12-bit word address, write data) reaches per-channel control/status, a control-block pointer, a debug word and read-only views of the descriptor the transfer engine is working on. Two global words hold the per-channel interrupt status and the per-channel enable mask.

The control/status word mixes three write behaviours. Some bits are write-one-to-clear flags. A fixed set of bits is replaced outright by the written value. A write-only bit resets the channel. When a write moves the run bit from 0 to 1, the block sends a one-cycle start pulse to that channel's engine. The engine reports the end of each control block with a one-cycle event. That event sets the end flag and, when the descriptor asks for it, the interrupt flag and the channel's interrupt line.

The highest channel has no slot in the main address window. A second window, selected by a side input, reaches it with the same per-channel layout.

Top module: `dma_chan_regif`

## Requirements
- R1: After reset, the enable word reads all ones in its low NCH bits. Interrupt status is 0, and every channel's control/status and block pointer are 0. All irq_o, start_o and err_o are low, and rdata_o is 0.
- R2: With alt_win_i low and addr_i below 0xF00, addr_i[11:8] selects the channel and addr_i[7:0] the word. With alt_win_i high, addr_i[7:0] selects a word of channel NCH-1 and addr_i[11:8] is ignored. Word offsets: 0x00 control/status, 0x04 block pointer, 0x08 info, 0x0C source, 0x10 destination, 0x14 length, 0x18 stride, 0x1C next pointer, 0x20 debug.
- R3: A read returns its value on rdata_o in the cycle after the request. rdata_o is 0 after any cycle that held no read. The block pointer and debug words read back what was last written. The info/source/destination/length/stride/next words return sh_*_i of the addressed channel.
- R4: An access to an undefined offset reads 0, changes no state, and pulses err_o high for the one cycle after the request. Writes to the read-only descriptor words and to 0xFE0 are ignored without an error.
- R5: A control/status write replaces the bits in mask 0x30FF0001 (bit 0 run, bits 23:16, bits 29:28) with the written value and keeps the others. Bits 30 (abort) and 31 (reset) always read 0.
- R6: Writing 1 to bit 1 clears the end flag. Writing 1 to bit 2 clears the interrupt flag, the channel's bit in the interrupt status word and its irq_o line.
- R7: Writing 1 to bit 31 zeroes the channel's control/status and block pointer before the rest of the write is applied. The channel's interrupt status bit and irq_o are left unchanged.
- R8: start_o[c] pulses for exactly one cycle, in the cycle after a control/status write that takes bit 0 of channel c from 0 to 1. A write that finds bit 0 already 1 gives no pulse, and the abort bit has no effect.
- R9: done_i[c] sets the end flag of channel c. When sh_info_i[c] bit 0 is 1, it also sets the interrupt flag, interrupt status bit c and irq_o[c]. A set wins over a clear written in the same cycle.
- R10: Address 0xFF0 holds the enable word: the low NCH bits of a write are stored and drive chan_en_o. Address 0xFE0 reads the interrupt status word, bit c for channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 write, 0 read |
| alt_win_i | input | 1 | Access goes through the last channel's window |
| addr_i | input | 12 | Byte address of the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| err_o | output | 1 | Undefined offset strobe |
| sh_info_i | input | NCH x 32 | Current descriptor info word per channel |
| sh_src_i | input | NCH x 32 | Current source address per channel |
| sh_dst_i | input | NCH x 32 | Current destination address per channel |
| sh_len_i | input | NCH x 32 | Remaining length per channel |
| sh_stride_i | input | NCH x 32 | Stride word per channel |
| sh_next_i | input | NCH x 32 | Next block pointer per channel |
| done_i | input | NCH | End-of-block event per channel |
| start_o | output | NCH | Start pulse per channel |
| irq_o | output | NCH | Interrupt line per channel |
| chan_en_o | output | NCH | Enable mask to the engines |
| cb_addr_o | output | NCH x 32 | Block pointer per channel |

## Verification
A wrong control/status bit, block pointer or interrupt status bit shows on rdata_o one cycle after the next read of that word. A lost or extra interrupt status bit shows on irq_o in the cycle after the event or write that went wrong. A wrong run-bit history shows up as a missing or extra start_o pulse in the cycle right after the write, so the bench compares irq_o, start_o, err_o and chan_en_o after every access. Random traffic with end-of-block events mixed in exposes collisions of clears and sets in the same cycle.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [DATA_W-1:0] CS_RW_MASK = 32'h30FF_0001;
  localparam int unsigned CS_RUN   = 0;
  localparam int unsigned CS_END   = 1;
  localparam int unsigned CS_INT   = 2;
  localparam int unsigned CS_RESET = 31;
  localparam int unsigned INFO_IRQ_EN = 0;

  localparam logic [ADDR_W-1:0] GLOB_BASE = 12'hF00;
  localparam logic [ADDR_W-1:0] GLOB_IRQ  = 12'hFE0;
  localparam logic [ADDR_W-1:0] GLOB_EN   = 12'hFF0;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CS, SEL_CB, SEL_INFO, SEL_SRC, SEL_DST,
    SEL_LEN, SEL_STRIDE, SEL_NEXT, SEL_DBG, SEL_GIRQ, SEL_GEN
  } reg_sel_e;

  function automatic reg_sel_e chan_word_sel(input logic [7:0] off);
    case (off)
      8'h00:   return SEL_CS;
      8'h04:   return SEL_CB;
      8'h08:   return SEL_INFO;
      8'h0C:   return SEL_SRC;
      8'h10:   return SEL_DST;
      8'h14:   return SEL_LEN;
      8'h18:   return SEL_STRIDE;
      8'h1C:   return SEL_NEXT;
      8'h20:   return SEL_DBG;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_regif_pkg::*;
#(
  parameter int unsigned NCH  = 16,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              alt_win_i,
  output logic [CH_W-1:0]   chan_o,
  output reg_sel_e          sel_o,
  output logic              bad_o
);
  always_comb begin
    chan_o = '0;
    sel_o  = SEL_NONE;
    if (alt_win_i) begin
      chan_o = CH_W'(NCH - 1);
      sel_o  = chan_word_sel(addr_i[7:0]);
    end else if (addr_i < GLOB_BASE) begin
      if (32'(addr_i[11:8]) < NCH) begin
        chan_o = CH_W'(addr_i[11:8]);
        sel_o  = chan_word_sel(addr_i[7:0]);
      end
    end else if (addr_i == GLOB_IRQ) begin
      sel_o = SEL_GIRQ;
    end else if (addr_i == GLOB_EN) begin
      sel_o = SEL_GEN;
    end
    bad_o = (sel_o == SEL_NONE);
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cs_i,
  input  logic              wr_cb_i,
  input  logic              wr_dbg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] cs_o,
  output logic [DATA_W-1:0] cb_o,
  output logic [DATA_W-1:0] dbg_o,
  output logic              irq_o,
  output logic              start_o
);
  logic [DATA_W-1:0] cs_q, cs_w, cs_d, cb_q, dbg_q;
  logic              pend_q, pend_d, start_q, start_d;

  always_comb begin
    cs_w = cs_q;
    if (wr_cs_i) begin
      if (wdata_i[CS_RESET]) cs_w = '0;       // reset first, rest of write on top
      if (wdata_i[CS_END])   cs_w[CS_END] = 1'b0;
      if (wdata_i[CS_INT])   cs_w[CS_INT] = 1'b0;
      cs_w = (cs_w & ~CS_RW_MASK) | (wdata_i & CS_RW_MASK);
    end
    cs_d   = cs_w;
    pend_d = pend_q;
    if (wr_cs_i && wdata_i[CS_INT]) pend_d = 1'b0;
    if (done_i) begin                          // engine event wins over clear
      cs_d[CS_END] = 1'b1;
      if (irq_en_i) begin
        cs_d[CS_INT] = 1'b1;
        pend_d       = 1'b1;
      end
    end
    start_d = wr_cs_i && !cs_q[CS_RUN] && cs_w[CS_RUN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= '0;
      cb_q    <= '0;
      dbg_q   <= '0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cs_q    <= cs_d;
      pend_q  <= pend_d;
      start_q <= start_d;
      if (wr_cs_i && wdata_i[CS_RESET]) cb_q <= '0;
      else if (wr_cb_i)                 cb_q <= wdata_i;
      if (wr_dbg_i) dbg_q <= wdata_i;
    end
  end

  assign cs_o    = cs_q;
  assign cb_o    = cb_q;
  assign dbg_o   = dbg_q;
  assign irq_o   = pend_q;
  assign start_o = start_q;
endmodule

// File: rtl/dma_chan_regif.sv
module dma_chan_regif
  import dma_regif_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic                        alt_win_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        err_o,
  input  logic [NCH-1:0][DATA_W-1:0]  sh_info_i,
  input  logic [NCH-1:0][DATA_W-1:0]  sh_src_i,
  input  logic [NCH-1:0][DATA_W-1:0]  sh_dst_i,
  input  logic [NCH-1:0][DATA_W-1:0]  sh_len_i,
  input  logic [NCH-1:0][DATA_W-1:0]  sh_stride_i,
  input  logic [NCH-1:0][DATA_W-1:0]  sh_next_i,
  input  logic [NCH-1:0]              done_i,
  output logic [NCH-1:0]              start_o,
  output logic [NCH-1:0]              irq_o,
  output logic [NCH-1:0]              chan_en_o,
  output logic [NCH-1:0][DATA_W-1:0]  cb_addr_o
);
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CH_W-1:0]            dec_chan;
  reg_sel_e                   dec_sel;
  logic                       dec_bad;
  logic                       wr_ok;
  logic [NCH-1:0][DATA_W-1:0] cs_a, cb_a, dbg_a;
  logic [NCH-1:0]             irq_a;
  logic [NCH-1:0]             en_q;
  logic [DATA_W-1:0]          rd_val, rdata_q;
  logic                       err_q;

  dma_reg_decode #(.NCH(NCH)) u_dec (
    .addr_i    (addr_i),
    .alt_win_i (alt_win_i),
    .chan_o    (dec_chan),
    .sel_o     (dec_sel),
    .bad_o     (dec_bad)
  );

  assign wr_ok = req_i && we_i && !dec_bad;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic hit;
    assign hit = wr_ok && (dec_chan == CH_W'(c));
    dma_chan_regs u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_cs_i  (hit && (dec_sel == SEL_CS)),
      .wr_cb_i  (hit && (dec_sel == SEL_CB)),
      .wr_dbg_i (hit && (dec_sel == SEL_DBG)),
      .wdata_i  (wdata_i),
      .done_i   (done_i[c]),
      .irq_en_i (sh_info_i[c][INFO_IRQ_EN]),
      .cs_o     (cs_a[c]),
      .cb_o     (cb_a[c]),
      .dbg_o    (dbg_a[c]),
      .irq_o    (irq_a[c]),
      .start_o  (start_o[c])
    );
  end

  always_comb begin
    case (dec_sel)
      SEL_CS:     rd_val = cs_a[dec_chan];
      SEL_CB:     rd_val = cb_a[dec_chan];
      SEL_INFO:   rd_val = sh_info_i[dec_chan];
      SEL_SRC:    rd_val = sh_src_i[dec_chan];
      SEL_DST:    rd_val = sh_dst_i[dec_chan];
      SEL_LEN:    rd_val = sh_len_i[dec_chan];
      SEL_STRIDE: rd_val = sh_stride_i[dec_chan];
      SEL_NEXT:   rd_val = sh_next_i[dec_chan];
      SEL_DBG:    rd_val = dbg_a[dec_chan];
      SEL_GIRQ:   rd_val = DATA_W'(irq_a);
      SEL_GEN:    rd_val = DATA_W'(en_q);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '1;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr_ok && (dec_sel == SEL_GEN)) en_q <= wdata_i[NCH-1:0];
      rdata_q <= (req_i && !we_i) ? rd_val : '0;
      err_q   <= req_i && dec_bad;
    end
  end

  assign rdata_o   = rdata_q;
  assign err_o     = err_q;
  assign irq_o     = irq_a;
  assign chan_en_o = en_q;
  assign cb_addr_o = cb_a;
endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk #(
  parameter int unsigned NCH = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           we_i,
  input logic           err_o,
  input logic [NCH-1:0] done_i,
  input logic [NCH-1:0] start_o,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] chan_en_o
);
  p_err_after_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i));

  p_start_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o));

  p_start_after_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |-> $past(req_i && we_i));

  p_start_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |=> ((start_o & $past(start_o)) == '0));

  p_en_needs_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_en_o) |-> $past(req_i && we_i));

  for (genvar c = 0; c < NCH; c++) begin : g_irq
    p_irq_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[c]) |-> $past(done_i[c]));
    p_irq_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[c]) |-> $past(req_i && we_i));
  end
endmodule

bind dma_chan_regif dma_regif_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_chan_regif_bench.sv
module dma_chan_regif_bench;
  localparam int NCH = 16;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h30FF_0001;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0, alt = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic err;
  logic [NCH-1:0][31:0] sh_info, sh_src, sh_dst, sh_len, sh_stride, sh_next;
  logic [NCH-1:0] done = '0;
  logic [NCH-1:0] start, irq, chan_en;
  logic [NCH-1:0][31:0] cb_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regif #(.NCH(NCH)) u_dma_chan_regif (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .alt_win_i(alt),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .sh_info_i(sh_info), .sh_src_i(sh_src), .sh_dst_i(sh_dst),
    .sh_len_i(sh_len), .sh_stride_i(sh_stride), .sh_next_i(sh_next),
    .done_i(done), .start_o(start), .irq_o(irq), .chan_en_o(chan_en),
    .cb_addr_o(cb_addr)
  );

  logic [31:0] m_cs [NCH];
  logic [31:0] m_cb [NCH];
  logic [31:0] m_dbg [NCH];
  logic [NCH-1:0] m_en, m_is;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // 0 undefined, 1 cs, 2 ptr, 3 info, 4 src, 5 dst, 6 len, 7 stride, 8 next, 9 dbg, 10 irq word, 11 enable
  function automatic int m_decode(input logic [11:0] a, input logic w, output int ch);
    int off;
    ch = 0;
    if (w) begin
      ch = NCH - 1; off = int'(a[7:0]);
    end else if (a < 12'hF00) begin
      ch = int'(a[11:8]);
      if (ch >= NCH) return 0;
      off = int'(a[7:0]);
    end else begin
      if (a == 12'hFE0) return 10;
      if (a == 12'hFF0) return 11;
      return 0;
    end
    case (off)
      'h00: return 1;  'h04: return 2;  'h08: return 3;
      'h0C: return 4;  'h10: return 5;  'h14: return 6;
      'h18: return 7;  'h1C: return 8;  'h20: return 9;
      default: return 0;
    endcase
  endfunction

  task automatic step(input logic rq, input logic w, input logic aw, input logic [11:0] a,
                      input logic [31:0] d, input logic [NCH-1:0] dn, input string tag);
    int ch, k;
    logic [31:0] exp_rd, old, nw;
    logic [NCH-1:0] exp_start;
    logic exp_err;
    string t_rd;
    req = rq; we = w; alt = aw; addr = a; wdata = d; done = dn;
    k = rq ? m_decode(a, aw, ch) : -1;
    exp_rd = '0; exp_err = rq && (k == 0); exp_start = '0;
    t_rd = "R3 read";
    if (rq && !w) begin
      case (k)
        1: begin exp_rd = m_cs[ch]; t_rd = "R5 cs read"; end
        2: exp_rd = m_cb[ch];
        3: exp_rd = sh_info[ch];
        4: exp_rd = sh_src[ch];
        5: exp_rd = sh_dst[ch];
        6: exp_rd = sh_len[ch];
        7: exp_rd = sh_stride[ch];
        8: exp_rd = sh_next[ch];
        9: exp_rd = m_dbg[ch];
        10: begin exp_rd = 32'(m_is); t_rd = "R10 irq word"; end
        11: begin exp_rd = 32'(m_en); t_rd = "R10 enable word"; end
        default: t_rd = "R4 undefined read";
      endcase
    end
    if (rq && w) begin
      case (k)
        1: begin
          old = m_cs[ch];
          nw = d[31] ? 32'h0 : old;
          if (d[31]) m_cb[ch] = '0;
          if (d[1]) nw[1] = 1'b0;
          if (d[2]) begin nw[2] = 1'b0; m_is[ch] = 1'b0; end
          nw = (nw & ~MASK) | (d & MASK);
          if (!old[0] && nw[0]) exp_start[ch] = 1'b1;
          m_cs[ch] = nw;
        end
        2: m_cb[ch] = d;
        9: m_dbg[ch] = d;
        11: m_en = d[NCH-1:0];
        default: ;
      endcase
    end
    for (int c = 0; c < NCH; c++) begin
      if (dn[c]) begin
        m_cs[c][1] = 1'b1;
        if (sh_info[c][0]) begin m_cs[c][2] = 1'b1; m_is[c] = 1'b1; end
      end
    end
    @(negedge clk);
    if (tag != "") t_rd = tag;
    check($sformatf("%s rdata @%h", t_rd, a), rdata, exp_rd);
    check($sformatf("%s R4 err @%h", tag, a), 32'(err), 32'(exp_err));
    check($sformatf("%s R8 start", tag), 32'(start), 32'(exp_start));
    check($sformatf("%s R9 irq", tag), 32'(irq), 32'(m_is));
    check($sformatf("%s R10 chan_en", tag), 32'(chan_en), 32'(m_en));
  endtask

  function automatic logic [11:0] ca(input int ch, input int off);
    return {ch[3:0], off[7:0]};
  endfunction

  task automatic rd(input logic [11:0] a, input string tag);
    step(1'b1, 1'b0, 1'b0, a, '0, '0, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, 1'b0, a, d, '0, tag);
  endtask
  task automatic idle(input logic [NCH-1:0] dn, input string tag);
    step(1'b0, 1'b0, 1'b0, '0, '0, dn, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    for (int c = 0; c < NCH; c++) begin
      sh_info[c] = $urandom; sh_src[c] = $urandom; sh_dst[c] = $urandom;
      sh_len[c] = $urandom; sh_stride[c] = $urandom; sh_next[c] = $urandom;
      m_cs[c] = '0; m_cb[c] = '0; m_dbg[c] = '0;
    end
    sh_info[5][0] = 1'b1;
    sh_info[6][0] = 1'b0;
    m_en = '1; m_is = '0;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports and through reads
    check("R1 irq after reset", 32'(irq), 32'h0);
    check("R1 start after reset", 32'(start), 32'h0);
    check("R1 err after reset", 32'(err), 32'h0);
    check("R1 rdata after reset", rdata, 32'h0);
    check("R1 chan_en after reset", 32'(chan_en), 32'h0000_FFFF);
    rd(12'hFF0, "R1 enable");
    rd(12'hFE0, "R1 irq word");
    for (int c = 0; c < NCH - 1; c++) begin
      rd(ca(c, 'h00), "R1 cs");
      rd(ca(c, 'h04), "R1 ptr");
    end
    step(1'b1, 1'b0, 1'b1, 12'h000, '0, '0, "R1 cs last chan");

    // R2 windows
    step(1'b1, 1'b1, 1'b1, 12'h720, 32'hCAFE_0015, '0, "R2 alt dbg write");
    step(1'b1, 1'b0, 1'b1, 12'h020, '0, '0, "R2 alt dbg read");
    rd(ca(7, 'h20), "R2 main ch7 dbg untouched");
    wr(ca(14, 'h04), 32'h1234_5678, "R2 ch14 ptr");
    rd(ca(14, 'h04), "R2 ch14 ptr read");
    step(1'b1, 1'b0, 1'b1, 12'hE04, '0, '0, "R2 alt ptr read");
    check("R2 cb_addr_o ch14", cb_addr[14], 32'h1234_5678);
    for (int o = 8; o <= 'h1C; o += 4) rd(ca(3, o), "R3 shadow");

    // R8 start pulse
    wr(ca(2, 0), 32'h0000_0001, "R8 start 0->1");
    wr(ca(2, 0), 32'h0000_0001, "R8 no start 1->1");
    wr(ca(2, 0), 32'h4000_0001, "R8 abort ignored");
    rd(ca(2, 0), "R5 abort reads 0");
    wr(ca(2, 0), 32'hFFFF_FFFE, "R5 masked write");
    rd(ca(2, 0), "R5 masked read");
    wr(ca(2, 0), 32'h0000_0001, "R8 restart");

    // R9 / R6 interrupt paths
    idle(16'h0020, "R9 done with irq enable");
    rd(ca(5, 0), "R9 cs after done");
    rd(12'hFE0, "R9 irq word");
    wr(ca(5, 0), 32'h0000_0004, "R6 clear int");
    rd(ca(5, 0), "R6 end kept");
    wr(ca(5, 0), 32'h0000_0002, "R6 clear end");
    rd(ca(5, 0), "R6 cs clean");
    idle(16'h0020, "R9 done again");
    step(1'b1, 1'b1, 1'b0, ca(5, 0), 32'h0000_0006, 16'h0020, "R9 set wins");
    rd(ca(5, 0), "R9 set wins cs");
    idle(16'h0040, "R9 done no irq enable");
    rd(ca(6, 0), "R9 end only");

    // R7 channel reset keeps interrupt status
    wr(ca(5, 4), 32'hDEAD_BEEF, "R7 ptr setup");
    wr(ca(5, 0), 32'h8000_0000, "R7 reset");
    rd(ca(5, 0), "R7 cs zero");
    rd(ca(5, 4), "R7 ptr zero");
    rd(12'hFE0, "R7 irq word kept");
    wr(ca(5, 0), 32'h8000_0001, "R7 reset with run from idle");
    wr(ca(5, 0), 32'h8000_0001, "R7 reset with run when running");
    rd(ca(5, 0), "R7 cs run");

    // R4 undefined and ignored accesses
    rd(12'h024, "R4 past last word");
    rd(12'h102, "R4 unaligned");
    rd(12'hF04, "R4 global hole");
    wr(12'h024, 32'hFFFF_FFFF, "R4 undefined write");
    wr(12'hFE0, 32'h0000_FFFF, "R4 irq word write ignored");
    rd(12'hFE0, "R4 irq word unchanged");
    wr(ca(3, 'h08), 32'h0, "R4 shadow write ignored");
    rd(ca(3, 'h08), "R4 shadow unchanged");

    // R10 enable word
    wr(12'hFF0, 32'hABCD_1234, "R10 enable write");
    rd(12'hFF0, "R10 enable read");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic aw, w;
      logic [11:0] a;
      logic [31:0] d;
      logic [NCH-1:0] dn;
      r = $urandom % 16;
      aw = (r == 0);
      if (r < 12) a = {4'($urandom % 15), 8'(($urandom % 9) * 4)};
      else if (r == 12) a = 12'hFE0;
      else if (r == 13) a = 12'hFF0;
      else a = 12'($urandom);
      w = $urandom % 2;
      d = $urandom;
      d[31] = ($urandom % 16 == 0);
      dn = ($urandom % 6 == 0) ? (NCH'(1) << ($urandom % NCH)) : '0;
      step(($urandom % 8) != 0, w, aw, a, d, dn, "");
    end

    summary();
  end
endmodule